// File: doc/BRIEF.md
# Switch State Register Block

This block sits on a processor's 32-bit register bus inside a 4 KB address window. It holds one switch state word and drives a single interrupt line. Logic outside the block loads a new state through a device-side strobe. When the block is built in output mode, software may also write the state. The written value goes out through a hook port, and the value the hook hands back is the one the block keeps.

Every change sets a pending flag. The interrupt line is high whenever a change is pending and interrupts are enabled. Software reads the interrupt status register to acknowledge a change. That read returns 1 and clears the flag, but only when a change is pending and interrupts are enabled.

A small state machine holds the pending flag and the enable bit together. Its four states are IDLE_MASKED, IDLE_ARMED, PEND_MASKED and PEND_ARMED. The transitions are:
- "arm": an enable write of 1.
- "mask": an enable write of 0.
- "change": a state load or an accepted write that differs from the stored value.
- "acknowledge": a status read in PEND_ARMED, which moves to IDLE_ARMED.

A change always lands in one of the two PEND states. When a change and an acknowledge occur in the same cycle, the change takes priority.

Top module: `sw_state_regblk`

## Requirements
- R1: After reset the state word, the pending flag and the interrupt enable are 0, and `irq` and `err` are low.
- R2: A read at offset 0x00 returns the NAME_LEN parameter. A read at 0x08 returns bit 0 = 1 in output mode and 0 in input mode, with all other bits 0.
- R3: A pulse on `dev_load` stores `dev_state` into the state word, which reads back at offset 0x0C, and sets the pending flag even when the value is unchanged.
- R4: `irq` is high exactly when a change is pending and the enable bit is 1. It reflects an access or load in the cycle after that access or load. Changing the enable while a change is pending drives `irq` to the new enable value.
- R5: A read at offset 0x10 returns 1 and clears the pending flag when a change is pending and enable is 1. Otherwise it returns 0 and changes nothing.
- R6: A write at offset 0x14 stores only bit 0 of the write data as the enable.
- R7: In output mode, a write at offset 0x0C pulses `hook_wr` in the same cycle, with `hook_wdata` equal to the write data. The value on `hook_rdata` in that cycle becomes the state word. The pending flag is set only if that value differs from the previous state.
- R8: A `dev_load` in the same cycle as an acknowledging status read leaves the pending flag set. A `dev_load` in the same cycle as a software state write makes `dev_state` the stored value.
- R9: Each of the following sets the sticky `err` output, changes no state, and makes a read return 0:
  - a read at any offset other than 0x00, 0x08, 0x0C or 0x10;
  - a write at any offset other than 0x04, 0x0C or 0x14;
  - a state write in input mode.
  A write at 0x04 is accepted and has no effect.
- R10: Each read access yields `bus_rvalid` high, with the data on `bus_rdata`, in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| dev_load | input | 1 | Device-side state load strobe |
| dev_state | input | DATA_W | State value to load |
| hook_wr | output | 1 | Software state write toward the hook (output mode) |
| hook_wdata | output | DATA_W | Value software wrote |
| hook_rdata | input | DATA_W | Value accepted by the hook, same cycle |
| irq | output | 1 | Interrupt line |
| err | output | 1 | Sticky illegal-access flag |

## Verification
A wrong state-machine state shows on `irq` in the very next cycle. A lost or duplicated pending flag shows in the next status read, which returns the wrong value or fails to clear the line. A corrupted state word only becomes visible when offset 0x0C is read, so the bench reads it back after every load and write. A missed illegal access leaves `err` low one cycle later, and that error stays visible for the rest of the run because the flag is sticky.

// File: rtl/sw_state_pkg.sv
package sw_state_pkg;
    localparam int OFF_NAME_LEN = 'h00;
    localparam int OFF_NAME_PTR = 'h04;
    localparam int OFF_FLAGS    = 'h08;
    localparam int OFF_STATE    = 'h0C;
    localparam int OFF_IRQ_STAT = 'h10;
    localparam int OFF_IRQ_EN   = 'h14;

    typedef enum logic [1:0] {
        ST_IDLE_MASKED,
        ST_IDLE_ARMED,
        ST_PEND_MASKED,
        ST_PEND_ARMED
    } irq_st_e;

    typedef struct packed {
        logic rd_len;
        logic rd_flags;
        logic rd_state;
        logic rd_stat;
        logic wr_ptr;
        logic wr_state;
        logic wr_en;
        logic bad;
    } acc_sel_t;
endpackage

// File: rtl/sw_bus_decode.sv
module sw_bus_decode
    import sw_state_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter bit OUTPUT_MODE = 1'b1
) (
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output acc_sel_t          sel
);
    always_comb begin
        sel = '0;
        if (en) begin
            if (!we) begin
                case (addr)
                    ADDR_W'(OFF_NAME_LEN): sel.rd_len   = 1'b1;
                    ADDR_W'(OFF_FLAGS):    sel.rd_flags = 1'b1;
                    ADDR_W'(OFF_STATE):    sel.rd_state = 1'b1;
                    ADDR_W'(OFF_IRQ_STAT): sel.rd_stat  = 1'b1;
                    default:               sel.bad      = 1'b1;
                endcase
            end else begin
                case (addr)
                    ADDR_W'(OFF_NAME_PTR): sel.wr_ptr = 1'b1;
                    ADDR_W'(OFF_STATE): begin
                        if (OUTPUT_MODE) sel.wr_state = 1'b1;
                        else             sel.bad      = 1'b1;
                    end
                    ADDR_W'(OFF_IRQ_EN):   sel.wr_en  = 1'b1;
                    default:               sel.bad    = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/sw_state_hold.sv
module sw_state_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_load,
    input  logic [DATA_W-1:0] dev_state,
    input  logic              sw_wr,
    input  logic [DATA_W-1:0] hook_rdata,
    output logic [DATA_W-1:0] state_q,
    output logic              change
);
    always_comb begin
        if (dev_load)   change = 1'b1;
        else if (sw_wr) change = (hook_rdata != state_q);
        else            change = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        state_q <= '0;
        else if (dev_load) state_q <= dev_state;
        else if (sw_wr)    state_q <= hook_rdata;
    end
endmodule

// File: rtl/sw_irq_fsm.sv
module sw_irq_fsm
    import sw_state_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    input  logic ack_rd,
    input  logic en_wr,
    input  logic en_val,
    output logic pending,
    output logic enable,
    output logic irq_o
);
    irq_st_e st_q, st_nxt;
    logic    cur_p, cur_e, nxt_p, nxt_e;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE_MASKED;
        else        st_q <= st_nxt;
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE_MASKED: begin cur_p = 1'b0; cur_e = 1'b0; end
            ST_IDLE_ARMED:  begin cur_p = 1'b0; cur_e = 1'b1; end
            ST_PEND_MASKED: begin cur_p = 1'b1; cur_e = 1'b0; end
            ST_PEND_ARMED:  begin cur_p = 1'b1; cur_e = 1'b1; end
        endcase
        nxt_e = en_wr ? en_val : cur_e;
        nxt_p = change | (cur_p & ~(ack_rd & cur_e));
        unique case ({nxt_p, nxt_e})
            2'b00: st_nxt = ST_IDLE_MASKED;
            2'b01: st_nxt = ST_IDLE_ARMED;
            2'b10: st_nxt = ST_PEND_MASKED;
            2'b11: st_nxt = ST_PEND_ARMED;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE_MASKED: begin pending = 1'b0; enable = 1'b0; irq_o = 1'b0; end
            ST_IDLE_ARMED:  begin pending = 1'b0; enable = 1'b1; irq_o = 1'b0; end
            ST_PEND_MASKED: begin pending = 1'b1; enable = 1'b0; irq_o = 1'b0; end
            ST_PEND_ARMED:  begin pending = 1'b1; enable = 1'b1; irq_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/sw_state_regblk.sv
module sw_state_regblk
    import sw_state_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 12,
    parameter int NAME_LEN    = 11,
    parameter bit OUTPUT_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              dev_load,
    input  logic [DATA_W-1:0] dev_state,
    output logic              hook_wr,
    output logic [DATA_W-1:0] hook_wdata,
    input  logic [DATA_W-1:0] hook_rdata,
    output logic              irq,
    output logic              err
);
    acc_sel_t          sel;
    logic [DATA_W-1:0] state_q;
    logic              change, pending, enable, irq_w;
    logic [DATA_W-1:0] rd_mux;
    logic              err_q;

    sw_bus_decode #(.ADDR_W(ADDR_W), .OUTPUT_MODE(OUTPUT_MODE)) u_dec (
        .en(bus_en), .we(bus_we), .addr(bus_addr), .sel(sel)
    );

    sw_state_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .dev_load(dev_load), .dev_state(dev_state),
        .sw_wr(sel.wr_state), .hook_rdata(hook_rdata),
        .state_q(state_q), .change(change)
    );

    sw_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .change(change), .ack_rd(sel.rd_stat),
        .en_wr(sel.wr_en), .en_val(bus_wdata[0]),
        .pending(pending), .enable(enable), .irq_o(irq_w)
    );

    always_comb begin
        rd_mux = '0;
        if (sel.rd_len)   rd_mux = DATA_W'(NAME_LEN);
        if (sel.rd_flags) rd_mux = DATA_W'(OUTPUT_MODE);
        if (sel.rd_state) rd_mux = state_q;
        if (sel.rd_stat)  rd_mux = DATA_W'(irq_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            bus_rvalid <= bus_en & ~bus_we;
            if (bus_en & ~bus_we) bus_rdata <= rd_mux;
            err_q <= err_q | sel.bad;
        end
    end

    assign hook_wr    = sel.wr_state;
    assign hook_wdata = bus_wdata;
    assign irq        = irq_w;
    assign err        = err_q;
endmodule

// File: rtl/sw_state_chk.sv
module sw_state_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rvalid,
    input logic              dev_load,
    input logic [DATA_W-1:0] dev_state,
    input logic [DATA_W-1:0] state_q,
    input logic              pending,
    input logic              enable,
    input logic              irq,
    input logic              err
);
    AST_LOAD_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        dev_load |=> pending); // R3
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_load |=> state_q == $past(dev_state)); // R3
    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == ADDR_W'('h10) && irq && !dev_load) |=> !irq); // R5
    AST_EN_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == ADDR_W'('h14)) |=> enable == $past(bus_wdata[0])); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R9
    AST_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we) |=> bus_rvalid); // R10
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> !bus_rvalid); // R10
endmodule

bind sw_state_regblk sw_state_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .dev_load(dev_load), .dev_state(dev_state), .state_q(state_q),
    .pending(pending), .enable(enable), .irq(irq), .err(err)
);

// File: tb/sw_state_regblk_bench.sv
module sw_state_regblk_bench;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam int NLEN = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          b_en = 0, b_we = 0, d_load = 0;
    logic [AW-1:0] b_addr = '0;
    logic [DW-1:0] b_wdata = '0, d_state = '0, h_mask = '1;
    logic [DW-1:0] rdata, h_wdata;
    logic          rvalid, h_wr, irq, err;
    logic [DW-1:0] h_rdata;
    assign h_rdata = h_wdata & h_mask;

    sw_state_regblk #(.DATA_W(DW), .ADDR_W(AW), .NAME_LEN(NLEN), .OUTPUT_MODE(1'b1)) u_sw_state_regblk (
        .clk(clk), .rst_n(rst_n), .bus_en(b_en), .bus_we(b_we), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
        .dev_load(d_load), .dev_state(d_state), .hook_wr(h_wr), .hook_wdata(h_wdata),
        .hook_rdata(h_rdata), .irq(irq), .err(err)
    );

    logic          i_en = 0, i_we = 0;
    logic [AW-1:0] i_addr = '0;
    logic [DW-1:0] i_wdata = '0;
    logic [DW-1:0] i_rdata, i_hwdata;
    logic          i_rvalid, i_hwr, i_irq, i_err;

    sw_state_regblk #(.DATA_W(DW), .ADDR_W(AW), .NAME_LEN(NLEN), .OUTPUT_MODE(1'b0)) u_sw_state_regblk_in (
        .clk(clk), .rst_n(rst_n), .bus_en(i_en), .bus_we(i_we), .bus_addr(i_addr),
        .bus_wdata(i_wdata), .bus_rdata(i_rdata), .bus_rvalid(i_rvalid),
        .dev_load(1'b0), .dev_state('0), .hook_wr(i_hwr), .hook_wdata(i_hwdata),
        .hook_rdata('0), .irq(i_irq), .err(i_err)
    );

    int    n_run = 0, n_fail = 0;
    bit    done = 0, started = 0;
    string tag = "R1";

    // Behavioural reference model, advanced on every rising edge
    logic [DW-1:0] m_state, m_rdata;
    bit            m_pend, m_en, m_err, m_rvalid;

    function automatic bit rd_ok(input logic [AW-1:0] a);
        return a == 12'h000 || a == 12'h008 || a == 12'h00C || a == 12'h010;
    endfunction
    function automatic bit wr_ok(input logic [AW-1:0] a);
        return a == 12'h004 || a == 12'h00C || a == 12'h014;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = '0; m_pend = 0; m_en = 0; m_err = 0; m_rvalid = 0; m_rdata = '0;
        end else begin
            bit            rd, wr, chg, ack;
            logic [DW-1:0] ret;
            rd  = b_en && !b_we;
            wr  = b_en && b_we;
            ret = b_wdata & h_mask;
            ack = 0;
            m_rvalid = rd;
            if (rd) begin
                if      (b_addr == 12'h000) m_rdata = NLEN;
                else if (b_addr == 12'h008) m_rdata = 1;
                else if (b_addr == 12'h00C) m_rdata = m_state;
                else if (b_addr == 12'h010) begin
                    m_rdata = (m_pend && m_en) ? 1 : 0;
                    ack = m_pend && m_en;
                end else m_rdata = 0;
                if (!rd_ok(b_addr)) m_err = 1;
            end
            if (wr && !wr_ok(b_addr)) m_err = 1;
            chg = 0;
            if (d_load) begin
                chg = 1; m_state = d_state;
            end else if (wr && b_addr == 12'h00C) begin
                chg = (ret != m_state); m_state = ret;
            end
            if (chg)      m_pend = 1;
            else if (ack) m_pend = 0;
            if (wr && b_addr == 12'h014) m_en = b_wdata[0];
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R4", DW'(irq), DW'(m_pend && m_en));
            chk("R9", DW'(err), DW'(m_err));
            chk("R10", DW'(rvalid), DW'(m_rvalid));
            if (m_rvalid) chk(tag, rdata, m_rdata);
        end
    end

    task automatic cyc(input bit en, input bit we, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input bit ld, input logic [DW-1:0] ls,
                       input string t);
        @(negedge clk);
        tag = t;
        b_en = en; b_we = we; b_addr = a; b_wdata = wd; d_load = ld; d_state = ls;
        #1;
        if (en && we && a == 12'h00C) begin
            chk("R7", DW'(h_wr), 1);
            chk("R7", h_wdata, wd);
        end
    endtask

    task automatic idle();
        cyc(0, 0, '0, '0, 0, '0, tag);
    endtask

    task automatic icyc(input bit en, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        @(negedge clk);
        i_en = en; i_we = we; i_addr = a; i_wdata = wd;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        started = 1;
        // R1 reset values
        @(negedge clk);
        chk("R1", DW'(irq), 0);
        chk("R1", DW'(err), 0);
        cyc(1, 0, 12'h00C, '0, 0, '0, "R1");
        cyc(1, 0, 12'h010, '0, 0, '0, "R1");
        // R2 length and flags
        cyc(1, 0, 12'h000, '0, 0, '0, "R2");
        cyc(1, 0, 12'h008, '0, 0, '0, "R2");
        // R3 load while masked, no irq
        cyc(0, 0, '0, '0, 1, 32'hCAFE_0001, "R3");
        cyc(1, 0, 12'h00C, '0, 0, '0, "R3");
        cyc(1, 0, 12'h010, '0, 0, '0, "R5");
        // R6 only bit 0: 0xFFFFFFFE -> disabled, 0x3 -> enabled; R4 line follows enable
        cyc(1, 1, 12'h014, 32'hFFFF_FFFE, 0, '0, "R6");
        cyc(1, 1, 12'h014, 32'h0000_0003, 0, '0, "R6");
        idle();
        cyc(1, 1, 12'h014, 32'h0, 0, '0, "R4");
        idle();
        cyc(1, 1, 12'h014, 32'h1, 0, '0, "R4");
        // R5 acknowledge then second read returns 0
        cyc(1, 0, 12'h010, '0, 0, '0, "R5");
        cyc(1, 0, 12'h010, '0, 0, '0, "R5");
        // R3 load of identical value still raises change
        cyc(0, 0, '0, '0, 1, 32'hCAFE_0001, "R3");
        cyc(1, 0, 12'h010, '0, 0, '0, "R5");
        // R7 hook path: mask clears low byte
        h_mask = 32'hFFFF_FF00;
        cyc(1, 1, 12'h00C, 32'h1234_5678, 0, '0, "R7");
        cyc(1, 0, 12'h00C, '0, 0, '0, "R7");
        cyc(1, 0, 12'h010, '0, 0, '0, "R7");
        cyc(1, 1, 12'h00C, 32'h1234_56AA, 0, '0, "R7");
        cyc(1, 0, 12'h010, '0, 0, '0, "R7");
        h_mask = '1;
        // R8 load collides with acknowledge; load collides with software write
        cyc(0, 0, '0, '0, 1, 32'h0000_0042, "R8");
        cyc(1, 0, 12'h010, '0, 1, 32'h0000_0043, "R8");
        cyc(1, 0, 12'h010, '0, 0, '0, "R8");
        cyc(1, 1, 12'h00C, 32'h0000_0099, 1, 32'h0000_0077, "R8");
        cyc(1, 0, 12'h00C, '0, 0, '0, "R8");
        cyc(1, 0, 12'h010, '0, 0, '0, "R8");
        // R9 name pointer write has no effect, then illegal accesses
        cyc(1, 1, 12'h004, 32'hDEAD_BEEF, 0, '0, "R9");
        cyc(1, 0, 12'h00C, '0, 0, '0, "R9");
        idle();
        chk("R9", DW'(err), 0);
        cyc(1, 0, 12'h014, '0, 0, '0, "R9");
        cyc(1, 1, 12'h000, 32'h5, 0, '0, "R9");
        cyc(1, 0, 12'h018, '0, 0, '0, "R9");
        cyc(1, 1, 12'hFFC, 32'h1, 0, '0, "R9");
        cyc(1, 0, 12'h00C, '0, 0, '0, "R9");
        // Mixed traffic, every cycle compared against the model
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a;
            case ($urandom % 8)
                0: a = 12'h000; 1: a = 12'h004; 2: a = 12'h008; 3: a = 12'h00C;
                4: a = 12'h010; 5: a = 12'h014; 6: a = 12'h010; default: a = 12'h00C;
            endcase
            h_mask = ($urandom % 2) ? '1 : 32'h0000_00F0;
            cyc($urandom % 4 != 0, $urandom % 2, a, $urandom % 4, ($urandom % 5) == 0,
                $urandom % 4, "R10");
        end
        idle();
        idle();
        // Input-mode instance: flags read 0, state write rejected (R2, R9)
        icyc(1, 0, 12'h008, '0);
        icyc(0, 0, '0, '0);
        chk("R2", DW'(i_rvalid), 1);
        chk("R2", i_rdata, 0);
        chk("R9", DW'(i_err), 0);
        icyc(1, 1, 12'h00C, 32'h55);
        #1;
        chk("R9", DW'(i_hwr), 0);
        icyc(1, 0, 12'h00C, '0);
        chk("R9", DW'(i_err), 1);
        icyc(0, 0, '0, '0);
        chk("R9", i_rdata, 0);
        chk("R9", DW'(i_irq), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule